// File: doc/BRIEF.md
# Record-Driven Reconfiguration Sequencer

This block is a bus master that turns a small table of 16-bit record words into the register traffic a direct-mode reconfiguration streamer expects. Each record opens with a header word. Its low eleven bits hold the first target offset, and its top five bits hold how many data words come right after it. For every record, the sequencer selects the channel and sets the streamer mode. It then walks the data words. For each one it writes the offset, writes the data word and sets the write-go bit. The offset moves up by one for each further word.

After every register write, the sequencer reads the control/status register again and again until the busy flag clears. Only then does it continue. A host loads the table through a plain write port, then pulses `start` with a channel number. The walk begins at table address 0. It ends with a `done` pulse when it meets an end-marker header or runs past the last table entry. It raises `err` if a busy poll never clears.

Top module: `recfg_seq`

## Requirements
- R1: A header word is split into length = bits [15:11] and starting offset = bits [10:0]. The data words of the record are the table entries that immediately follow the header.
- R2: For a record of nonzero length, the first two bus writes are the channel value to address 0x38, then the mode word 0x4 (mode 2'b01 in bits [3:2]) to address 0x3A.
- R3: Each data word produces three writes in this order: its offset to 0x3B, the data word to 0x3C, and 0x5 (mode bits plus the go bit, bit 0) to 0x3A.
- R4: The offset written for the k-th data word of a record is the starting offset plus k, modulo 2^11. The next header is the entry after the last data word.
- R5: After each write, the sequencer reads address 0x3A until bit 8 (busy) reads 0. The next write follows only after that read. The number of reads after a write equals the number of busy reads plus one.
- R6: A header of length 0 produces no bus access, and the next entry is treated as a header.
- R7: A header of 0xFFFF, or a walk that passes the last table entry (including inside a record), ends the run. The run ends with a one-cycle `done` pulse and no further access.
- R8: At most one access is outstanding; read and write are never both high. While waitrequest is high, address, data, read and write stay unchanged.
- R9: If POLL_LIMIT consecutive poll reads return busy, the sequencer stops issuing accesses and sets `err`, and no `done` pulse follows. The next accepted `start` clears `err`.
- R10: A `start` pulse while a run is in progress is ignored; the channel used is the one captured at the accepted start.
- R11: After reset, `run`, `done`, `err`, `avm_read` and `avm_write` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_we | input | 1 | Table load strobe |
| load_addr | input | AW | Table load address |
| load_data | input | 16 | Table load word |
| start | input | 1 | Begin a walk at table address 0 |
| chan | input | CH_W | Logical channel for this walk |
| run | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| err | output | 1 | Busy-poll timeout flag |
| avm_address | output | BA_W | Bus address |
| avm_read | output | 1 | Bus read request |
| avm_write | output | 1 | Bus write request |
| avm_writedata | output | DW | Bus write data |
| avm_readdata | input | DW | Bus read data |
| avm_waitrequest | input | 1 | Bus stall |

## Verification
The bench builds the block with a 16-entry table (AW = 4) and POLL_LIMIT = 8. The small table lets a single run reach the end-of-table exit, including a record cut short by the table end. The small poll limit makes the timeout path a few dozen cycles long. A streamer model varies the busy length per write and stalls pseudo-randomly. The bench derives the full expected write list from the table contents by arithmetic, covering offset wrap at 2^11, zero-length records and the end marker.

// File: rtl/recfg_pkg.sv
package recfg_pkg;
   localparam int WORD_W = 16;
   localparam int OFS_W  = 11;
   localparam int LEN_W  = 5;
   localparam logic [WORD_W-1:0] END_MARK = 16'hFFFF;

   typedef enum logic [2:0] {ST_CH, ST_MODE, ST_OFS, ST_DATA, ST_GO} step_e;

   typedef enum logic [3:0] {
      S_IDLE, S_HDR_WAIT, S_HDR, S_DAT_WAIT, S_DAT,
      S_WR, S_WR_WAIT, S_RD, S_RD_WAIT
   } state_e;
endpackage

// File: rtl/recfg_mem.sv
module recfg_mem #(
   parameter int AW        = 4,
   parameter bit REG_RDATA = 1'b1
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [15:0]   wdata,
   input  logic [AW-1:0] raddr,
   output logic [15:0]   rdata
);
   localparam int DEPTH = 1 << AW;

   logic [15:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   generate
      if (REG_RDATA) begin : g_reg
         always_ff @(posedge clk) rdata <= store[raddr];
      end else begin : g_comb
         assign rdata = store[raddr];
      end
   endgenerate
endmodule

// File: rtl/recfg_bus.sv
module recfg_bus #(
   parameter int BA_W     = 8,
   parameter int DW       = 32,
   parameter int BUSY_BIT = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic            req_wr,
   input  logic [BA_W-1:0] req_addr,
   input  logic [DW-1:0]   req_wdata,
   output logic            ack,
   output logic            busy_seen,
   output logic [BA_W-1:0] avm_address,
   output logic            avm_read,
   output logic            avm_write,
   output logic [DW-1:0]   avm_writedata,
   input  logic [DW-1:0]   avm_readdata,
   input  logic            avm_waitrequest
);
   logic unused_rd;
   assign unused_rd = ^avm_readdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack           <= 1'b0;
         busy_seen     <= 1'b0;
         avm_address   <= '0;
         avm_read      <= 1'b0;
         avm_write     <= 1'b0;
         avm_writedata <= '0;
      end else begin
         ack <= 1'b0;
         if (!(avm_read || avm_write)) begin
            if (req) begin
               avm_read      <= !req_wr;
               avm_write     <= req_wr;
               avm_address   <= req_addr;
               avm_writedata <= req_wdata;
            end
         end else if (!avm_waitrequest) begin
            avm_read  <= 1'b0;
            avm_write <= 1'b0;
            ack       <= 1'b1;
            busy_seen <= avm_readdata[BUSY_BIT];
         end
      end
   end

   // R8: a stalled request is held unchanged
   a_r8_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (avm_read || avm_write) && avm_waitrequest |=>
      $stable(avm_address) && $stable(avm_writedata) && $stable(avm_read) && $stable(avm_write));
endmodule

// File: rtl/recfg_ctl.sv
module recfg_ctl
   import recfg_pkg::*;
#(
   parameter int           AW         = 4,
   parameter int           CH_W       = 10,
   parameter int           DW         = 32,
   parameter int           BA_W       = 8,
   parameter int           POLL_LIMIT = 1024,
   parameter logic [1:0]   MODE_VAL   = 2'b01,
   parameter int           MODE_LSB   = 2,
   parameter int           GO_BIT     = 0,
   parameter logic [BA_W-1:0] A_CHAN  = 'h38,
   parameter logic [BA_W-1:0] A_CSR   = 'h3A,
   parameter logic [BA_W-1:0] A_OFS   = 'h3B,
   parameter logic [BA_W-1:0] A_DATA  = 'h3C
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [CH_W-1:0] chan,
   output logic [AW-1:0]   mem_raddr,
   input  logic [15:0]     mem_rdata,
   output logic            req,
   output logic            req_wr,
   output logic [BA_W-1:0] req_addr,
   output logic [DW-1:0]   req_wdata,
   input  logic            ack,
   input  logic            busy_seen,
   output logic            run_o,
   output logic            done_o,
   output logic            err_o
);
   localparam int PC_W = $clog2(POLL_LIMIT + 1);
   localparam logic [DW-1:0] CTL_MODE = DW'(MODE_VAL) << MODE_LSB;
   localparam logic [DW-1:0] CTL_GO   = CTL_MODE | (DW'(1) << GO_BIT);

   state_e            state;
   step_e             step_q;
   logic [AW:0]       ptr;
   logic [OFS_W-1:0]  off_q;
   logic [LEN_W-1:0]  left_q;
   logic [15:0]       data_q;
   logic [CH_W-1:0]   chan_q;
   logic [PC_W-1:0]   poll_cnt;

   assign mem_raddr = ptr[AW-1:0];
   assign run_o     = (state != S_IDLE);
   assign req       = (state == S_WR) || (state == S_RD);
   assign req_wr    = (state == S_WR);

   always_comb begin
      req_addr  = A_CSR;
      req_wdata = CTL_GO;
      if (state != S_RD) begin
         unique case (step_q)
            ST_CH:   begin req_addr = A_CHAN; req_wdata = DW'(chan_q); end
            ST_MODE: begin req_addr = A_CSR;  req_wdata = CTL_MODE;    end
            ST_OFS:  begin req_addr = A_OFS;  req_wdata = DW'(off_q);  end
            ST_DATA: begin req_addr = A_DATA; req_wdata = DW'(data_q); end
            default: begin req_addr = A_CSR;  req_wdata = CTL_GO;      end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         step_q   <= ST_CH;
         ptr      <= '0;
         off_q    <= '0;
         left_q   <= '0;
         data_q   <= '0;
         chan_q   <= '0;
         poll_cnt <= '0;
         done_o   <= 1'b0;
         err_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state)
            S_IDLE: if (start) begin
               chan_q <= chan;
               ptr    <= '0;
               err_o  <= 1'b0;
               state  <= S_HDR_WAIT;
            end
            S_HDR_WAIT: if (ptr[AW]) begin
               done_o <= 1'b1;
               state  <= S_IDLE;
            end else state <= S_HDR;
            S_HDR: if (mem_rdata == END_MARK) begin
               done_o <= 1'b1;
               state  <= S_IDLE;
            end else begin
               ptr    <= ptr + 1'b1;
               off_q  <= mem_rdata[OFS_W-1:0];
               left_q <= mem_rdata[15-:LEN_W];
               step_q <= ST_CH;
               state  <= (mem_rdata[15-:LEN_W] == '0) ? S_HDR_WAIT : S_WR;
            end
            S_DAT_WAIT: if (ptr[AW]) begin
               done_o <= 1'b1;
               state  <= S_IDLE;
            end else state <= S_DAT;
            S_DAT: begin
               data_q <= mem_rdata;
               step_q <= ST_OFS;
               state  <= S_WR;
            end
            S_WR: begin
               poll_cnt <= '0;
               state    <= S_WR_WAIT;
            end
            S_WR_WAIT: if (ack) state <= S_RD;
            S_RD: state <= S_RD_WAIT;
            S_RD_WAIT: if (ack) begin
               if (busy_seen) begin
                  if (poll_cnt == PC_W'(POLL_LIMIT - 1)) begin
                     err_o <= 1'b1;
                     state <= S_IDLE;
                  end else begin
                     poll_cnt <= poll_cnt + 1'b1;
                     state    <= S_RD;
                  end
               end else begin
                  unique case (step_q)
                     ST_CH:   begin step_q <= ST_MODE; state <= S_WR; end
                     ST_MODE: state <= S_DAT_WAIT;
                     ST_OFS:  begin step_q <= ST_DATA; state <= S_WR; end
                     ST_DATA: begin step_q <= ST_GO;   state <= S_WR; end
                     default: begin
                        off_q  <= off_q + 1'b1;
                        left_q <= left_q - 1'b1;
                        ptr    <= ptr + 1'b1;
                        state  <= (left_q == LEN_W'(1)) ? S_HDR_WAIT : S_DAT_WAIT;
                     end
                  endcase
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R9: the poll counter never reaches the limit itself
   a_r9_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
      poll_cnt < PC_W'(POLL_LIMIT));
   // R9: a raised error coincides with an idle sequencer
   a_r9_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
      err_o && !$past(err_o) |-> !run_o);
   // R7: done is a single-cycle pulse and leaves the sequencer idle
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !run_o ##1 !done_o);
   // R10: a start during a run leaves the captured channel alone
   a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      run_o && start |=> $stable(chan_q));
endmodule

// File: rtl/recfg_seq.sv
module recfg_seq #(
   parameter int AW         = 6,
   parameter int CH_W       = 10,
   parameter int DW         = 32,
   parameter int BA_W       = 8,
   parameter int BUSY_BIT   = 8,
   parameter int POLL_LIMIT = 1024,
   parameter bit REG_RDATA  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_we,
   input  logic [AW-1:0]   load_addr,
   input  logic [15:0]     load_data,
   input  logic            start,
   input  logic [CH_W-1:0] chan,
   output logic            run,
   output logic            done,
   output logic            err,
   output logic [BA_W-1:0] avm_address,
   output logic            avm_read,
   output logic            avm_write,
   output logic [DW-1:0]   avm_writedata,
   input  logic [DW-1:0]   avm_readdata,
   input  logic            avm_waitrequest
);
   generate
      if (AW < 1 || AW > 12) begin : g_bad_aw
         $error("recfg_seq: AW out of range");
      end
      if (BUSY_BIT >= DW || CH_W > DW || DW < 16) begin : g_bad_dw
         $error("recfg_seq: data width too small");
      end
      if (POLL_LIMIT < 1 || BA_W < 6) begin : g_bad_misc
         $error("recfg_seq: poll limit or address width invalid");
      end
   endgenerate

   logic [AW-1:0]   mem_raddr;
   logic [15:0]     mem_rdata;
   logic            req, req_wr, ack, busy_seen;
   logic [BA_W-1:0] req_addr;
   logic [DW-1:0]   req_wdata;

   recfg_mem #(.AW(AW), .REG_RDATA(REG_RDATA)) mem_i (
      .clk(clk), .we(load_we), .waddr(load_addr), .wdata(load_data),
      .raddr(mem_raddr), .rdata(mem_rdata));

   recfg_ctl #(.AW(AW), .CH_W(CH_W), .DW(DW), .BA_W(BA_W), .POLL_LIMIT(POLL_LIMIT)) ctl_i (
      .clk(clk), .rst_n(rst_n), .start(start), .chan(chan),
      .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
      .req(req), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
      .ack(ack), .busy_seen(busy_seen),
      .run_o(run), .done_o(done), .err_o(err));

   recfg_bus #(.BA_W(BA_W), .DW(DW), .BUSY_BIT(BUSY_BIT)) bus_i (
      .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
      .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .busy_seen(busy_seen),
      .avm_address(avm_address), .avm_read(avm_read), .avm_write(avm_write),
      .avm_writedata(avm_writedata), .avm_readdata(avm_readdata),
      .avm_waitrequest(avm_waitrequest));

   // R8: never a read and a write at once
   a_r8_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
      !(avm_read && avm_write));
   // R2, R3: writes only hit the four streamer registers
   a_r3_write_map: assert property (@(posedge clk) disable iff (!rst_n)
      avm_write |-> (avm_address == BA_W'('h38) || avm_address == BA_W'('h3A) ||
                     avm_address == BA_W'('h3B) || avm_address == BA_W'('h3C)));
   // R5: polls always target the control/status register
   a_r5_poll_csr: assert property (@(posedge clk) disable iff (!rst_n)
      avm_read |-> avm_address == BA_W'('h3A));
endmodule

// File: tb/recfg_seq_tb.sv
module recfg_seq_tb_top;
   localparam int AW    = 4;
   localparam int DEPTH = 1 << AW;
   localparam int PL    = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_we = 1'b0;
   logic [AW-1:0] load_addr = '0;
   logic [15:0] load_data = '0;
   logic        start = 1'b0;
   logic [9:0]  chan = '0;
   logic        run, done, err;
   logic [7:0]  avm_address;
   logic        avm_read, avm_write;
   logic [31:0] avm_writedata, avm_readdata;
   logic        avm_waitrequest;

   always #2.5 clk = ~clk;

   recfg_seq #(.AW(AW), .POLL_LIMIT(PL)) dut_i (
      .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
      .load_data(load_data), .start(start), .chan(chan), .run(run), .done(done),
      .err(err), .avm_address(avm_address), .avm_read(avm_read), .avm_write(avm_write),
      .avm_writedata(avm_writedata), .avm_readdata(avm_readdata),
      .avm_waitrequest(avm_waitrequest));

   // streamer register bank model
   logic [15:0] lfsr = 16'hACE1;
   logic        stall_en = 1'b0, stuck = 1'b0, clr = 1'b0;
   int          busy_left = 0, log_n = 0, rd_since = 0, rd_total = 0, early_wr = 0;
   logic [7:0]  log_a [256];
   logic [31:0] log_d [256];
   int          reads_after [256];

   assign avm_waitrequest = stall_en & lfsr[0];
   assign avm_readdata    = (stuck || busy_left != 0) ? 32'h100 : 32'h0;

   always @(posedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (clr) begin
         log_n <= 0; rd_since <= 0; rd_total <= 0; early_wr <= 0; busy_left <= 0;
      end else if (avm_write && !avm_waitrequest) begin
         log_a[log_n] <= avm_address;
         log_d[log_n] <= avm_writedata;
         if (log_n > 0) reads_after[log_n-1] <= rd_since;
         if (busy_left != 0) early_wr <= early_wr + 1;
         busy_left <= log_n % 3;
         rd_since  <= 0;
         log_n     <= log_n + 1;
      end else if (avm_read && !avm_waitrequest) begin
         rd_since <= rd_since + 1;
         rd_total <= rd_total + 1;
         if (busy_left != 0) busy_left <= busy_left - 1;
      end
   end

   int done_cnt = 0;
   always @(negedge clk) if (done) done_cnt <= done_cnt + 1;

   int n_chk = 0, n_fail = 0;
   logic [15:0] bmem [DEPTH];
   logic [7:0]  exp_a [256];
   logic [31:0] exp_d [256];
   int          exp_n;

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic chk(input string rq, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual %0h expected %0h", rq, act, exp);
      end
   endtask

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog actual hung expected finished");
      summary();
   end

   task automatic load(input int a, input logic [15:0] d);
      @(negedge clk);
      load_we = 1'b1; load_addr = AW'(a); load_data = d; bmem[a] = d;
      @(negedge clk);
      load_we = 1'b0;
   endtask

   task automatic fill(input logic [15:0] d);
      for (int a = 0; a < DEPTH; a++) load(a, d);
   endtask

   task automatic push(input logic [7:0] a, input logic [31:0] d);
      exp_a[exp_n] = a; exp_d[exp_n] = d; exp_n++;
   endtask

   task automatic build_exp(input logic [9:0] ch);
      int p = 0;
      exp_n = 0;
      while (p < DEPTH) begin
         int ln, of;
         if (bmem[p] == 16'hFFFF) break;
         ln = int'(bmem[p][15:11]); of = int'(bmem[p][10:0]); p++;
         if (ln == 0) continue;
         push(8'h38, 32'(ch)); push(8'h3A, 32'h4);
         for (int i = 0; i < ln; i++) begin
            if (p >= DEPTH) break;
            push(8'h3B, 32'((of + i) & 2047)); push(8'h3C, 32'(bmem[p])); push(8'h3A, 32'h5);
            p++;
         end
      end
   endtask

   task automatic go(input logic [9:0] ch, input bit restart);
      @(negedge clk);
      clr = 1'b1; done_cnt = 0;
      @(negedge clk);
      clr = 1'b0; chan = ch; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (restart) begin
         repeat (20) @(negedge clk);
         chan = ~ch; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (run) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic compare(input string rq, input bit polls);
      chk({rq, " write count"}, log_n, exp_n);
      for (int k = 0; k < exp_n && k < log_n; k++) begin
         chk({rq, " write addr"}, log_a[k], exp_a[k]);
         chk({rq, " write data"}, log_d[k], exp_d[k]);
      end
      if (polls && log_n > 0) begin
         for (int k = 0; k + 1 < log_n; k++) chk("R5 reads after write", reads_after[k], (k % 3) + 1);
         chk("R5 reads after last write", rd_since, ((log_n - 1) % 3) + 1);
         chk("R5 write while busy", early_wr, 0);
      end
      chk("R7 done pulse count", done_cnt, 1);
      chk("R9 err clear", err, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 run", run, 0); chk("R11 done", done, 0); chk("R11 err", err, 0);
      chk("R11 read", avm_read, 0); chk("R11 write", avm_write, 0);
      rst_n = 1'b1;
      stall_en = 1'b1;

      // R1 R2 R3 R4 R6 R7 R10: records, zero length, offset wrap, end marker, restart ignored
      fill(16'h0000);
      load(0, 16'h1800); load(1, 16'h2820); load(2, 16'h23B0); load(3, 16'h81D4);
      load(4, 16'h0005);
      load(5, 16'h1FFE); load(6, 16'hA5A5); load(7, 16'h5A5A); load(8, 16'h0F0F);
      load(9, 16'h0801); load(10, 16'h1234);
      load(11, 16'hFFFF);
      build_exp(10'd5);
      go(10'd5, 1'b1);
      compare("R4 R10 sample table", 1'b1);

      // R7: walk passes the table end inside a record
      fill(16'h0000);
      load(0, 16'h0810); load(1, 16'hBEEF);
      load(14, 16'h2020); load(15, 16'hCAFE);
      build_exp(10'h3FF);
      go(10'h3FF, 1'b0);
      compare("R7 end of table", 1'b1);

      // R7: immediate end marker
      load(0, 16'hFFFF);
      build_exp(10'd1);
      go(10'd1, 1'b0);
      compare("R7 end marker", 1'b0);
      chk("R7 no reads", rd_total, 0);

      // R6: all length-zero headers
      fill(16'h0000);
      build_exp(10'd2);
      go(10'd2, 1'b0);
      compare("R6 empty records", 1'b0);
      chk("R6 no reads", rd_total, 0);

      // R9: busy never clears
      load(0, 16'h1000); load(1, 16'h0001); load(2, 16'h0002);
      stuck = 1'b1;
      go(10'd9, 1'b0);
      chk("R9 writes before abort", log_n, 1);
      chk("R9 poll reads", rd_total, PL);
      chk("R9 err set", err, 1);
      chk("R9 no done", done_cnt, 0);
      chk("R9 run low", run, 0);
      stuck = 1'b0;

      // R9: next start clears err and the walk completes
      build_exp(10'd9);
      go(10'd9, 1'b0);
      compare("R9 recovery", 1'b1);

      // R8: same table with no stalls
      stall_en = 1'b0;
      go(10'd9, 1'b0);
      compare("R8 no stall", 1'b1);

      summary();
   end
endmodule